// File: doc/BRIEF.md
# Multiphase Interleaved PWM Generator with Current Balancing

The block drives up to four pulse-width modulated outputs from one shared 256-count switching counter. Each active output is delayed from the counter by an equal share of the period, so the phases are interleaved evenly. With three active outputs they sit 120 degrees apart. A voltage loop supplies one duty command for all outputs. A digital current sample for each channel lets the block lengthen the pulses of channels carrying less than the average current and shorten those carrying more. This spreads the load evenly across the phases.

The number of active phases comes from strap inputs at start-up. Outputs beyond that count float and are left out of the average. A sequencer selects a drive mode: normal modulation, forced low, forced high or released to high impedance. A per-output enable can also release a single output. High impedance is modelled by an output-enable bit beside each data bit. A one-cycle tick marks every sub-period, so it pulses at the combined ripple rate.

Control is a two-state sequencer. In SEQ_HOLD (reset, and the first clock after reset is released) the straps are captured and everything is quiet. The transition SEQ_HOLD to SEQ_RUN is taken unconditionally on that clock, and SEQ_RUN is then kept until reset. Each channel has a pulse state machine with states PH_LO and PH_HI. The transition PH_LO to PH_HI is taken at a period start whose latched duty is non-zero. The transition PH_HI to PH_LO is taken when the local count reaches the latched duty.

Top module: `mpwm_gen`

## Requirements
- R1: The active count n is found from the straps (a high strap marks a channel unused). Channel 0 is always active and strap bit 0 is ignored. n is the index of the lowest high strap among bits 1 to 3, or 4 if none of those is high. The straps are captured on the first clock after reset release. From then on `act_cnt` shows n; it shows 0 before that.
- R2: While reset is asserted and during the first clock after release, all output-enable bits, all output bits and the tick are 0.
- R3: A 256-count counter starts at 0 after the hold cycle and increments every clock. Channel k has local count (counter - floor(k*256/n)) mod 256. Its modulated level is high exactly while the local count is below its latched duty.
- R4: `ripple_tick` is high in each cycle where the counter equals the offset of an active channel. It therefore pulses n times per period and never in two consecutive cycles.
- R5: A channel latches its duty on the clock at which its local count wraps from 255 to 0, using the inputs present just before that clock. Input changes at any other time do not alter the pulse under way.
- R6: The average is floor(sum of active samples / n). The trimmed duty is duty_cmd - floor((sample_k - average)/2). With equal samples, every channel gets exactly duty_cmd, and a larger command never gives a shorter pulse.
- R7: The trimmed duty saturates to 0 and 255.
- R8: Channels at index n or above have output-enable 0 and output 0, and their samples do not enter the average.
- R9: `drv_mode` encoding: 0 modulate, 1 force low, 2 force high, 3 release all outputs. The output-enable bit is active channel AND `drv_en[k]` AND mode not 3. The data bit is 0 whenever its enable is 0.
- R10: Clearing `drv_en[k]` releases only output k. Timing and latched duty continue, so the pulse pattern is intact when the output is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_off | input | 4 | Strap per channel, high marks the channel unused |
| duty_cmd | input | 8 | Shared duty command from the voltage loop |
| cur_flat | input | 32 | Current sample per channel, channel k in bits 8k+7:8k |
| drv_mode | input | 2 | Drive mode: 0 modulate, 1 low, 2 high, 3 release |
| drv_en | input | 4 | Per-output enable |
| pwm_o | output | 4 | Output data bits |
| pwm_oe | output | 4 | Output-enable bits (0 means high impedance) |
| ripple_tick | output | 1 | One-cycle pulse per sub-period |
| act_cnt | output | 3 | Active channel count |

## Verification
The bench runs six strap settings, including patterns with bit 0 set and with gaps above the first high strap, to tell the count decoding apart from a plain population count. For each setting it applies random commands and samples that change every clock, which exposes any duty latched at the wrong moment. Equal samples separate the trim path from the plain command. Strongly unbalanced samples with extreme commands drive the trim into both saturation limits. A final phase of random modes and enables shows forcing and release to be independent of the running phase timing.

// File: rtl/mpwm_pkg.sv
package mpwm_pkg;

    // Drive mode from the sequencer
    typedef enum logic [1:0] {
        DRV_PWM   = 2'd0,
        DRV_LOW   = 2'd1,
        DRV_HIGH  = 2'd2,
        DRV_FLOAT = 2'd3
    } drv_mode_e;

    // Top-level sequencing
    typedef enum logic {
        SEQ_HOLD = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_st_e;

    // Per-channel pulse state
    typedef enum logic {
        PH_LO = 1'b0,
        PH_HI = 1'b1
    } ph_st_e;

endpackage

// File: rtl/mpwm_avg.sv
module mpwm_avg #(
    parameter int NCH   = 4,
    parameter int CUR_W = 8,
    parameter int NW    = 3
) (
    input  logic [NCH*CUR_W-1:0] cur_flat,
    input  logic [NCH-1:0]       act_mask,
    input  logic [NW-1:0]        n_act,
    output logic [CUR_W-1:0]     avg
);
    localparam int SUM_W = CUR_W + $clog2(NCH + 1);
    localparam int RSH   = SUM_W + 1;
    localparam int RECIP = (2 ** RSH) / 3 + 1;   // reciprocal of three
    localparam int PW    = SUM_W + RSH;

    logic [SUM_W-1:0] sum;
    logic [PW-1:0]    prod;
    logic [SUM_W-1:0] quo;

    always_comb begin
        sum = '0;
        for (int k = 0; k < NCH; k++) begin
            if (act_mask[k])
                sum = sum + SUM_W'(cur_flat[k*CUR_W +: CUR_W]);
        end
    end

    assign prod = PW'(sum) * PW'(RECIP);

    always_comb begin
        case (n_act)
            NW'(1):  quo = sum;
            NW'(2):  quo = sum >> 1;
            NW'(3):  quo = SUM_W'(prod >> RSH);
            default: quo = sum >> 2;
        endcase
    end

    assign avg = CUR_W'(quo);

endmodule

// File: rtl/mpwm_chan.sv
module mpwm_chan
    import mpwm_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int CUR_W   = 8,
    parameter int TRIM_SH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] off,
    input  logic [CNT_W-1:0] duty_cmd,
    input  logic [CUR_W-1:0] cur,
    input  logic [CUR_W-1:0] avg,
    output logic             level,
    output logic             cyc_start
);
    localparam int TW = ((CNT_W > CUR_W) ? CNT_W : CUR_W) + 3;
    localparam logic signed [TW-1:0] TOP_V = TW'((2 ** CNT_W) - 1);

    ph_st_e                  st, st_nx;
    logic [CNT_W-1:0]        duty_q;
    logic [CNT_W-1:0]        lc;
    logic                    lc_end;
    logic signed [CUR_W+1:0] delta;
    logic signed [CUR_W+1:0] corr;
    logic signed [TW-1:0]    tsum;
    logic [CNT_W-1:0]        trim;
    logic                    want_hi;

    assign lc        = cnt - off;
    assign lc_end    = &lc;
    assign cyc_start = (lc == '0);

    // current deviation from the average, scaled down
    assign delta = $signed({2'b00, cur}) - $signed({2'b00, avg});
    assign corr  = delta >>> TRIM_SH;
    assign tsum  = TW'($signed({1'b0, duty_cmd})) - TW'(corr);

    always_comb begin
        if (tsum < 0)
            trim = '0;
        else if (tsum > TOP_V)
            trim = '1;
        else
            trim = tsum[CNT_W-1:0];
    end

    assign want_hi = lc_end ? (trim != '0) : ((lc + CNT_W'(1)) < duty_q);

    always_comb begin
        st_nx = st;
        unique case (st)
            PH_LO: st_nx = want_hi ? PH_HI : PH_LO;
            PH_HI: st_nx = want_hi ? PH_HI : PH_LO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= PH_LO;
            duty_q <= '0;
        end else if (run) begin
            st <= st_nx;
            if (lc_end)
                duty_q <= trim;
        end
    end

    assign level = (st == PH_HI);

endmodule

// File: rtl/mpwm_gen.sv
module mpwm_gen
    import mpwm_pkg::*;
#(
    parameter int NCH     = 4,
    parameter int CNT_W   = 8,
    parameter int CUR_W   = 8,
    parameter int TRIM_SH = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NCH-1:0]       strap_off,
    input  logic [CNT_W-1:0]     duty_cmd,
    input  logic [NCH*CUR_W-1:0] cur_flat,
    input  logic [1:0]           drv_mode,
    input  logic [NCH-1:0]       drv_en,
    output logic [NCH-1:0]       pwm_o,
    output logic [NCH-1:0]       pwm_oe,
    output logic                 ripple_tick,
    output logic [$clog2(NCH+1)-1:0] act_cnt
);
    localparam int NW     = $clog2(NCH + 1);
    localparam int PERIOD = 2 ** CNT_W;

    seq_st_e          st;
    logic [NW-1:0]    n_q;
    logic [CNT_W-1:0] cnt;
    logic             run;
    logic [NCH-1:0]   act_mask;
    logic [NCH-1:0]   level;
    logic [NCH-1:0]   start;
    logic [CUR_W-1:0] avg;
    drv_mode_e        mode;

    function automatic logic [NW-1:0] strap_count(input logic [NCH-1:0] s);
        logic [NW-1:0] n;
        n = NW'(NCH);
        for (int i = NCH - 1; i >= 1; i--) begin
            if (s[i])
                n = NW'(i);
        end
        return n;
    endfunction

    // sequencer state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= SEQ_HOLD;
            n_q <= '0;
            cnt <= '0;
        end else begin
            unique case (st)
                SEQ_HOLD: begin
                    n_q <= strap_count(strap_off);
                    st  <= SEQ_RUN;
                end
                SEQ_RUN: cnt <= cnt + CNT_W'(1);
            endcase
        end
    end

    assign run     = (st == SEQ_RUN);
    assign act_cnt = n_q;
    assign mode    = drv_mode_e'(drv_mode);

    always_comb begin
        for (int k = 0; k < NCH; k++)
            act_mask[k] = run && (k < int'(n_q));
    end

    mpwm_avg #(.NCH(NCH), .CUR_W(CUR_W), .NW(NW)) avg_i (
        .cur_flat (cur_flat),
        .act_mask (act_mask),
        .n_act    (n_q),
        .avg      (avg)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        logic [CNT_W-1:0] off;

        always_comb begin
            case (n_q)
                NW'(2):  off = CNT_W'((k * PERIOD) / 2);
                NW'(3):  off = CNT_W'((k * PERIOD) / 3);
                NW'(4):  off = CNT_W'((k * PERIOD) / 4);
                default: off = '0;
            endcase
        end

        mpwm_chan #(.CNT_W(CNT_W), .CUR_W(CUR_W), .TRIM_SH(TRIM_SH)) ch_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (run),
            .cnt       (cnt),
            .off       (off),
            .duty_cmd  (duty_cmd),
            .cur       (cur_flat[k*CUR_W +: CUR_W]),
            .avg       (avg),
            .level     (level[k]),
            .cyc_start (start[k])
        );
    end

    // output process
    always_comb begin
        for (int k = 0; k < NCH; k++) begin
            pwm_oe[k] = act_mask[k] && drv_en[k] && (mode != DRV_FLOAT);
            pwm_o[k]  = 1'b0;
            unique case (mode)
                DRV_PWM:   pwm_o[k] = pwm_oe[k] && level[k];
                DRV_LOW:   pwm_o[k] = 1'b0;
                DRV_HIGH:  pwm_o[k] = pwm_oe[k];
                DRV_FLOAT: pwm_o[k] = 1'b0;
            endcase
        end
        ripple_tick = |(start & act_mask);
    end

endmodule

// File: rtl/mpwm_gen_chk.sv
module mpwm_gen_chk #(
    parameter int NCH = 4,
    parameter int NW  = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic [1:0]     drv_mode,
    input logic [NCH-1:0] drv_en,
    input logic [NCH-1:0] pwm_o,
    input logic [NCH-1:0] pwm_oe,
    input logic           ripple_tick,
    input logic [NW-1:0]  act_cnt
);
    logic [NCH-1:0] cnt_mask;

    always_comb begin
        for (int k = 0; k < NCH; k++)
            cnt_mask[k] = (k < int'(act_cnt));
    end

    p_count_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        int'(act_cnt) <= NCH);

    p_hold_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cnt == '0) |-> (pwm_oe == '0 && !ripple_tick));

    p_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ripple_tick |=> !ripple_tick);

    p_unused_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_oe & ~cnt_mask) == '0);

    p_released_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_o & ~pwm_oe) == '0);

    p_force_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_mode == 2'd1) |-> (pwm_o == '0));

    p_force_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_mode == 2'd2) |-> (pwm_o == pwm_oe));

    p_oe_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_oe & ~drv_en) == '0);

endmodule

bind mpwm_gen mpwm_gen_chk #(.NCH(NCH), .NW(NW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .drv_mode    (drv_mode),
    .drv_en      (drv_en),
    .pwm_o       (pwm_o),
    .pwm_oe      (pwm_oe),
    .ripple_tick (ripple_tick),
    .act_cnt     (act_cnt)
);

// File: tb/mpwm_gen_tb.sv
module mpwm_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  strap_off = '0;
    logic [7:0]  duty_cmd = '0;
    logic [31:0] cur_flat = '0;
    logic [1:0]  drv_mode = '0;
    logic [3:0]  drv_en = '1;
    logic [3:0]  pwm_o, pwm_oe;
    logic        ripple_tick;
    logic [2:0]  act_cnt;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    string tag = "R3";

    // bench model
    bit mrun = 0;
    int mcnt = 0;
    int mn = 0;
    int mduty[4] = '{0, 0, 0, 0};

    always #2.5 clk = ~clk;

    mpwm_gen dut_i (
        .clk(clk), .rst_n(rst_n), .strap_off(strap_off), .duty_cmd(duty_cmd),
        .cur_flat(cur_flat), .drv_mode(drv_mode), .drv_en(drv_en),
        .pwm_o(pwm_o), .pwm_oe(pwm_oe), .ripple_tick(ripple_tick), .act_cnt(act_cnt)
    );

    function automatic int f_count(input logic [3:0] s);
        if (s[1]) return 1;
        if (s[2]) return 2;
        if (s[3]) return 3;
        return 4;
    endfunction

    function automatic int f_off(input int k, input int n);
        return (k * 256) / n;
    endfunction

    function automatic int f_cur(input int k);
        return int'(cur_flat[k*8 +: 8]);
    endfunction

    function automatic int f_trim(input int k, input int n);
        int sum = 0;
        int av, d, t;
        for (int j = 0; j < n; j++) sum += f_cur(j);
        av = sum / n;
        d  = f_cur(k) - av;
        t  = int'(duty_cmd) - (d >>> 1);
        if (t < 0) t = 0;
        if (t > 255) t = 255;
        return t;
    endfunction

    task automatic chk(input string rq, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", rq, act, exp, $time);
        end
    endtask

    // model of the coming clock edge, from the inputs now applied
    task automatic model_edge();
        if (!rst_n) begin
            mrun = 0; mcnt = 0; mn = 0;
            for (int k = 0; k < 4; k++) mduty[k] = 0;
        end else if (!mrun) begin
            mrun = 1; mcnt = 0; mn = f_count(strap_off);
        end else begin
            for (int k = 0; k < mn; k++)
                if (((mcnt - f_off(k, mn)) & 255) == 255) mduty[k] = f_trim(k, mn);
            mcnt = (mcnt + 1) & 255;
        end
    endtask

    task automatic check_all();
        int e_o = 0, e_oe = 0, e_tick = 0;
        for (int k = 0; k < 4; k++) begin
            bit act = mrun && (k < mn);
            bit oe  = act && drv_en[k] && (drv_mode != 2'd3);
            bit lvl = 0, val;
            if (act) begin
                lvl = ((mcnt - f_off(k, mn)) & 255) < mduty[k];
                if (mcnt == f_off(k, mn)) e_tick = 1;
            end
            case (drv_mode)
                2'd1:    val = 0;
                2'd2:    val = 1;
                default: val = lvl;
            endcase
            if (oe) e_oe |= (1 << k);
            if (oe && val) e_o |= (1 << k);
        end
        if (!mrun) begin
            chk("R2 pwm_oe", int'(pwm_oe), 0);
            chk("R2 pwm_o", int'(pwm_o), 0);
            chk("R2 tick", int'(ripple_tick), 0);
            chk("R1 act_cnt", int'(act_cnt), 0);
        end else begin
            chk({tag, " pwm_o"}, int'(pwm_o), e_o);
            chk((mn < 4) ? "R8/R9 pwm_oe" : "R9 pwm_oe", int'(pwm_oe), e_oe);
            chk("R4 ripple_tick", int'(ripple_tick), e_tick);
            chk("R1 act_cnt", int'(act_cnt), mn);
        end
    endtask

    task automatic cyc();
        model_edge();
        @(negedge clk);
        check_all();
    endtask

    task automatic set_cur(input int c0, input int c1, input int c2, input int c3);
        cur_flat = {8'(c3), 8'(c2), 8'(c1), 8'(c0)};
    endtask

    initial begin
        logic [3:0] cfgs[6] = '{4'b0000, 4'b1000, 4'b0100, 4'b0010, 4'b1011, 4'b1100};
        void'($urandom(32'd1234));
        @(negedge clk);
        foreach (cfgs[i]) begin
            rst_n = 0; strap_off = cfgs[i]; drv_mode = 0; drv_en = '1;
            tag = "R2";
            repeat (3) cyc();
            rst_n = 1;
            cyc();                 // hold cycle, still quiet
            // random command and samples every clock
            tag = "R5";
            for (int c = 0; c < 600; c++) begin
                duty_cmd = 8'($urandom);
                cur_flat = $urandom;
                cyc();
            end
            // equal samples: plain command on every channel
            tag = "R6";
            for (int c = 0; c < 300; c++) begin
                if (c % 97 == 0) duty_cmd = 8'($urandom);
                set_cur(120, 120, 120, 120);
                cyc();
            end
            // strong imbalance at both ends of the command range
            tag = "R7";
            duty_cmd = 8'd250; set_cur(0, 255, 255, 255);
            repeat (300) cyc();
            duty_cmd = 8'd3; set_cur(255, 0, 0, 0);
            repeat (300) cyc();
            duty_cmd = 8'd255; set_cur(0, 0, 0, 0);
            repeat (300) cyc();
            // random modes and per-output enables
            tag = "R9/R10";
            for (int c = 0; c < 400; c++) begin
                if (c % 8 == 0) begin
                    drv_mode = ($urandom % 3 == 0) ? 2'($urandom) : 2'd0;
                    drv_en   = 4'($urandom);
                end
                duty_cmd = 8'($urandom);
                cur_flat = $urandom;
                cyc();
            end
            drv_mode = 0; drv_en = '1;
            tag = "R10";
            repeat (300) cyc();
        end
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(5 * 150000);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule